// File: doc/BRIEF.md
# Interrupt Pending State Tracker

This block keeps the pending state of a bank of interrupt lines, each configured as edge-sensitive or level-sensitive. Every interrupt owns exactly one stored pending latch plus a copy of the line's level from the previous clock. The pending value that software reads, and that drives the interrupt output, is the latch combined with the live level of level-sensitive lines. So a level interrupt stays pending as long as its line is high, even after it has been acknowledged or cleared.

Software sets or clears pending latches and enable bits in 32-bit banks through a small synchronous write port. Each write is write-1-to-act. A read port returns one 32-bit bank of visible pending status. An acknowledge port takes an interrupt number and clears that interrupt's latch. A single output is high while any enabled interrupt is visibly pending. The interrupt lines are assumed to be synchronous to the clock already. The interrupt count must be a power-of-two multiple of 32.

Top module: `irq_pend_track`

## Requirements
- R1: While reset is low, and right after it is released, every pending latch, level bit and enable bit is 0. All read banks return 0 and `irq_out` is 0.
- R2: The visible pending bit of interrupt k is `latch[k] | (~cfg_edge[k] & level[k])`. Reading bank b returns interrupts 32*b+31 down to 32*b, with bit j holding interrupt 32*b+j.
- R3: At each clock the level bit takes the line's value. A rising line (line 1, level bit 0) sets the latch only when `cfg_edge` is 1 (edge mode). A level-mode rise does not set the latch.
- R4: A falling line leaves the latch untouched. An edge interrupt stays pending after its line drops. A level interrupt with a clear latch stops reading pending one clock after its line drops.
- R5: An acknowledge (`ack_valid` with `ack_id`) clears the latch of that interrupt at the next clock. A level interrupt whose line is still high keeps reading pending.
- R6: A write with `wr_op` = 0 sets the latches of the bank `wr_bank` wherever `wr_data` has a 1, in either trigger mode. Bits written 0 change nothing.
- R7: A write with `wr_op` = 1 clears the latches wherever `wr_data` has a 1. A level interrupt whose line is high keeps reading pending.
- R8: When an acknowledge and an edge-mode rise hit the same interrupt in the same cycle, the latch stays set.
- R9: `wr_op` = 2 sets enable bits and `wr_op` = 3 clears enable bits, both write-1-to-act. `irq_out` is 1 exactly when some interrupt is both enabled and visibly pending.
- R10: `rd_data` and `irq_out` follow `cfg_edge` and `rd_bank` combinationally, within the same cycle. For example, switching a high level line to edge mode with no latch set drops its pending status at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N_IRQ | Synchronous interrupt lines |
| cfg_edge | input | N_IRQ | Trigger mode per interrupt: 1 edge, 0 level |
| wr_en | input | 1 | Register write strobe |
| wr_op | input | 2 | 0 set-pending, 1 clear-pending, 2 set-enable, 3 clear-enable |
| wr_bank | input | BW | 32-interrupt bank selected by the write |
| wr_data | input | 32 | Write-1-to-act bit mask |
| rd_bank | input | BW | Bank selected for reading |
| rd_data | output | 32 | Visible pending status of the read bank |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_id | input | IDW | Interrupt number being acknowledged |
| irq_out | output | 1 | Any enabled interrupt visibly pending |

## Verification
The per-interrupt assertions check the latch rules on every cycle: an edge-mode rise sets the latch, a level-mode rise does not, a falling line leaves the latch alone, an acknowledge clears it, and a rise wins over a simultaneous acknowledge. They also check that the output stays quiet while no enable bit is set. The bench scenarios are needed for the visible OR with the live level. These scenarios cover a level interrupt that survives an acknowledge or a clear write, the bank mapping of reads, write-1-to-act masking with zero bits, and the same-cycle effect of changing the trigger mode.

// File: rtl/irq_pend_track.sv
module irq_pend_track #(
  parameter int N_IRQ = 64,
  localparam int NB  = N_IRQ / 32,
  localparam int BW  = (NB > 1) ? $clog2(NB) : 1,
  localparam int IDW = $clog2(N_IRQ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_in,
  input  logic [N_IRQ-1:0] cfg_edge,
  input  logic             wr_en,
  input  logic [1:0]       wr_op,
  input  logic [BW-1:0]    wr_bank,
  input  logic [31:0]      wr_data,
  input  logic [BW-1:0]    rd_bank,
  output logic [31:0]      rd_data,
  input  logic             ack_valid,
  input  logic [IDW-1:0]   ack_id,
  output logic             irq_out
);

  logic [N_IRQ-1:0] latch_q, lvl_q, en_q;
  logic [N_IRQ-1:0] sw_set, sw_clr, en_set, en_clr;
  logic [N_IRQ-1:0] ack_vec, rise, set_v, clr_v, pend_vis;
  logic [31:0]      bank_v [NB];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam logic [BW-1:0] BID = BW'(b);
    wire hit = wr_en && (wr_bank == BID);
    assign sw_set[b*32 +: 32] = (hit && wr_op == 2'd0) ? wr_data : 32'd0;
    assign sw_clr[b*32 +: 32] = (hit && wr_op == 2'd1) ? wr_data : 32'd0;
    assign en_set[b*32 +: 32] = (hit && wr_op == 2'd2) ? wr_data : 32'd0;
    assign en_clr[b*32 +: 32] = (hit && wr_op == 2'd3) ? wr_data : 32'd0;
    assign bank_v[b] = pend_vis[b*32 +: 32];
  end

  assign ack_vec  = ack_valid ? ({{(N_IRQ-1){1'b0}}, 1'b1} << ack_id) : '0;
  assign rise     = irq_in & ~lvl_q;
  assign set_v    = (rise & cfg_edge) | sw_set;
  assign clr_v    = ack_vec | sw_clr;
  assign pend_vis = latch_q | (lvl_q & ~cfg_edge);
  assign rd_data  = bank_v[rd_bank];
  assign irq_out  = |(pend_vis & en_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '0;
      lvl_q   <= '0;
      en_q    <= '0;
    end else begin
      latch_q <= set_v | (latch_q & ~clr_v);
      lvl_q   <= irq_in;
      en_q    <= en_set | (en_q & ~en_clr);
    end
  end

  for (genvar i = 0; i < N_IRQ; i++) begin : g_chk
    assert_edge_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rise[i] && cfg_edge[i]) |=> latch_q[i]);
    assert_level_no_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rise[i] && !cfg_edge[i] && !sw_set[i] && !latch_q[i]) |=> !latch_q[i]);
    assert_fall_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_in[i] && lvl_q[i] && !sw_set[i] && !clr_v[i]) |=> $stable(latch_q[i]));
    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_vec[i] && !set_v[i]) |=> !latch_q[i]);
    assert_rise_beats_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_vec[i] && rise[i] && cfg_edge[i]) |=> latch_q[i]);
  end

  assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq_out);

endmodule

// File: tb/tb_irq_pend_track.sv
module tb_irq_pend_track;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] irq_in, cfg_edge;
  logic        wr_en;
  logic [1:0]  wr_op;
  logic        wr_bank, rd_bank;
  logic [31:0] wr_data, rd_data;
  logic        ack_valid;
  logic [5:0]  ack_id;
  logic        irq_out;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_pend_track #(.N_IRQ(64)) dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_edge(cfg_edge),
    .wr_en(wr_en), .wr_op(wr_op), .wr_bank(wr_bank), .wr_data(wr_data),
    .rd_bank(rd_bank), .rd_data(rd_data), .ack_valid(ack_valid),
    .ack_id(ack_id), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic bank, output logic [31:0] v);
    rd_bank = bank;
    #1;
    v = rd_data;
  endtask

  task automatic wr(input logic [1:0] op, input logic bank, input logic [31:0] d);
    wr_en = 1'b1; wr_op = op; wr_bank = bank; wr_data = d;
    step();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic ack(input int id);
    ack_valid = 1'b1; ack_id = 6'(id);
    step();
    ack_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; irq_in = '0; cfg_edge = '0; wr_en = 1'b0; wr_op = '0;
    wr_bank = 1'b0; wr_data = '0; rd_bank = 1'b0; ack_valid = 1'b0; ack_id = '0;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rst_n = 1'b0; irq_in = '1; cfg_edge = '1;
    step(); step();
    rd(1'b0, v); check("R1 bank0 in reset", v, 32'h0);
    rd(1'b1, v); check("R1 bank1 in reset", v, 32'h0);
    check("R1 irq_out in reset", {31'b0, irq_out}, 32'h0);
    do_reset();
    rd(1'b0, v); check("R1 bank0 after reset", v, 32'h0);
    wr(2'd0, 1'b0, 32'h8);
    check("R1 enables cleared", {31'b0, irq_out}, 32'h0);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    do_reset();
    cfg_edge[5] = 1'b1; irq_in[5] = 1'b1;
    step();
    rd(1'b0, v); check("R3 edge rise latches", v, 32'h20);
    irq_in[5] = 1'b0;
    step();
    rd(1'b0, v); check("R4 edge stays after fall", v, 32'h20);
    ack(5);
    rd(1'b0, v); check("R5 ack clears edge", v, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] v;
    do_reset();
    irq_in[40] = 1'b1;
    step();
    rd(1'b1, v); check("R2 level pending bank1 bit8", v, 32'h100);
    rd(1'b0, v); check("R2 bank0 unaffected", v, 32'h0);
    ack(40);
    rd(1'b1, v); check("R5 level survives ack", v, 32'h100);
    irq_in[40] = 1'b0;
    step();
    rd(1'b1, v); check("R3 R4 level rise left no latch", v, 32'h0);
  endtask

  task automatic t_sw();
    logic [31:0] v;
    do_reset();
    wr(2'd0, 1'b0, 32'h80);
    rd(1'b0, v); check("R6 set-pending level-mode", v, 32'h80);
    rd(1'b1, v); check("R6 other bank untouched", v, 32'h0);
    wr(2'd1, 1'b0, 32'h0);
    rd(1'b0, v); check("R6 zero bits no effect", v, 32'h80);
    wr(2'd1, 1'b0, 32'h80);
    rd(1'b0, v); check("R7 clear-pending", v, 32'h0);
    irq_in[7] = 1'b1;
    step();
    wr(2'd1, 1'b0, 32'h80);
    rd(1'b0, v); check("R7 level high after clear", v, 32'h80);
    irq_in[7] = 1'b0;
    step();
    rd(1'b0, v); check("R7 clear removed latch", v, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    do_reset();
    cfg_edge[9] = 1'b1;
    wr(2'd0, 1'b0, 32'h200);
    irq_in[9] = 1'b1;
    ack(9);
    rd(1'b0, v); check("R8 rise beats ack", v, 32'h200);
    ack(9);
    rd(1'b0, v); check("R5 edge cleared with line high", v, 32'h0);
  endtask

  task automatic t_enable();
    logic [31:0] v;
    do_reset();
    wr(2'd0, 1'b0, 32'h8);
    check("R9 pending but disabled", {31'b0, irq_out}, 32'h0);
    wr(2'd2, 1'b0, 32'h8);
    check("R9 enabled pending", {31'b0, irq_out}, 32'h1);
    wr(2'd3, 1'b0, 32'h8);
    check("R9 enable cleared", {31'b0, irq_out}, 32'h0);
    wr(2'd2, 1'b0, 32'h8);
    wr(2'd1, 1'b0, 32'h8);
    check("R9 pending cleared", {31'b0, irq_out}, 32'h0);
  endtask

  task automatic t_live();
    logic [31:0] v;
    do_reset();
    wr(2'd2, 1'b1, 32'h100);
    irq_in[40] = 1'b1;
    step();
    check("R10 level drives irq_out", {31'b0, irq_out}, 32'h1);
    cfg_edge[40] = 1'b1;
    rd(1'b1, v); check("R10 mode switch drops pending", v, 32'h0);
    check("R10 mode switch drops irq_out", {31'b0, irq_out}, 32'h0);
  endtask

  initial begin
    t_reset();
    t_edge();
    t_level();
    t_sw();
    t_collide();
    t_enable();
    t_live();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule